// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This unit watches a processor's activity through four event counters (PMC1 to PMC4) and a single interrupt line. Every cycle it receives a vector of event strobes, a cache-miss valid flag with its latency, and a free-running 64-bit time base. Each counter has its own event selector. A latency-qualified miss code lets a counter count only the misses slower than a programmable threshold. When a counter's top bit turns on, or when a chosen time-base bit rises, the unit latches a pending interrupt. That interrupt stays raised until software clears it.

A trigger mode keeps PMC2 to PMC4 frozen until PMC1 reaches its top bit or an interrupt is pending. A global freeze bit stops all counting, while the registers stay accessible. Privileged software reaches the control word, the PMC3/PMC4 selectors, the status bit and the four counters through one register port. Unprivileged software sees a read-only copy of the control word on a separate output.

Top module: `pmu_core`

## Requirements
- R1: After reset every counter, the control word, the selector word and the pending flag read as zero, and `pm_int_o` is low.
- R2: Register map: address 0 is the control word, 1 the selector word (PMC3 select in bits 5:0, PMC4 select in bits 11:6), 2 the status word (bit 0 is pending), 3 reads zero, and 4 to 7 are PMC1 to PMC4. In the control word, bit 0 is freeze, bit 1 is the time-base interrupt enable, bits 3:2 are the time-base tap, bits 9:4 are the threshold, bit 10 is the PMC1 interrupt enable, bit 11 is the PMC2–PMC4 interrupt enable, bit 12 is the trigger, bits 19:13 are the PMC1 select and bits 25:20 are the PMC2 select. Bits 31:26 always read zero.
- R3: A counter whose select code is c (c ≥ 2) adds one in each cycle in which `evt_i[c]` is high. Code 0 never counts. The PMC1 select is 7 bits wide (codes up to 127); the other selects are 6 bits wide.
- R4: Select code 1 counts a cycle only when `miss_vld_i` is high and `miss_lat_i` is strictly greater than the threshold. `evt_i[1]` has no effect on it.
- R5: When a counter's bit 31 changes from 0 to 1, the pending flag is set if the matching enable is 1 (bit 10 for PMC1, bit 11 for any of PMC2–PMC4). With the enable at 0, the pending flag is not set.
- R6: The time-base tap code selects `tb_i[0]`, `tb_i[8]`, `tb_i[12]` or `tb_i[16]` for codes 0, 1, 2 and 3. A 0-to-1 change of the selected bit sets the pending flag when bit 1 is set. Changes on other bits, falling edges, and changes while bit 1 is clear have no effect.
- R7: The pending flag drives `pm_int_o` and holds until software writes 1 to status bit 0. Writing 0 leaves it set. If a set condition occurs in the same cycle as the clear, the flag stays set.
- R8: With the trigger bit at 1, PMC2–PMC4 do not count until PMC1 bit 31 is 1 or the pending flag is set. After that they count, even if both conditions go away, until the control word is written again.
- R9: With freeze at 1, no counter increments, but register writes still take effect.
- R10: A counter write takes effect in place of an increment in the same cycle.
- R11: `usr_ctrl_o` always equals the control word read at address 0. The control word, including the time-base interrupt enable, changes only when address 0 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | EVT_N (128) | Per-cycle event strobes, indexed by select code |
| miss_vld_i | input | 1 | A cache miss completes this cycle |
| miss_lat_i | input | LAT_W (8) | Latency of that miss |
| tb_i | input | TB_W (64) | Free-running time base |
| reg_we_i | input | 1 | Privileged register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| usr_ctrl_o | output | 32 | Read-only mirror of the control word |
| pm_int_o | output | 1 | Performance-monitor interrupt, level |

## Verification
A corrupted counter or selector shows up on the next read of that counter as a value off by the missed or extra increments. Such an error never corrects itself, because counters only step upward or get overwritten. A wrong trigger-release state shows within one event cycle as PMC2–PMC4 counting while they should be held, or staying still while they should count. A lost or spurious edge detection shows on `pm_int_o` in the same cycle the counter or time-base tap changes. The bench checks the interrupt right after each such edge.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned SEL1_W = 7;
    localparam int unsigned SELN_W = 6;
    localparam int unsigned THR_W  = 6;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_SEL34 = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd2;

    // control word, most significant field first
    typedef struct packed {
        logic [5:0]        rsvd;
        logic [SELN_W-1:0] sel2;
        logic [SEL1_W-1:0] sel1;
        logic              trig;
        logic              grp_ie;
        logic              pmc1_ie;
        logic [THR_W-1:0]  thresh;
        logic [1:0]        tb_tap;
        logic              tb_ie;
        logic              freeze;
    } ctrl_t;

endpackage

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
    parameter int unsigned EVT_N     = 128,
    parameter int unsigned SEL_W     = 6,
    parameter int unsigned LAT_W     = 8,
    parameter int unsigned THR_W     = 6,
    parameter int unsigned MISS_CODE = 1
) (
    input  logic [EVT_N-1:0] evt_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             miss_vld_i,
    input  logic [LAT_W-1:0] miss_lat_i,
    input  logic [THR_W-1:0] thresh_i,
    output logic             hit_o
);

    logic slow_miss;

    always_comb begin
        slow_miss = miss_vld_i && (miss_lat_i > LAT_W'(thresh_i));
        hit_o     = 1'b0;
        if (sel_i == SEL_W'(MISS_CODE)) begin
            hit_o = slow_miss;
        end else if (sel_i != '0) begin
            hit_o = evt_i[sel_i];
        end
    end

endmodule

// File: rtl/pmu_tb_pick.sv
module pmu_tb_pick #(
    parameter int unsigned TB_W = 64
) (
    input  logic [TB_W-1:0] tb_i,
    input  logic [1:0]      tap_i,
    output logic            bit_o
);

    localparam int unsigned IDX_W = $clog2(TB_W);

    logic [IDX_W-1:0] idx;

    always_comb begin
        unique case (tap_i)
            2'd0:    idx = IDX_W'(0);
            2'd1:    idx = IDX_W'(8);
            2'd2:    idx = IDX_W'(12);
            default: idx = IDX_W'(16);
        endcase
        bit_o = tb_i[idx];
    end

endmodule

// File: rtl/pmu_core.sv
module pmu_core
    import pmu_pkg::*;
#(
    parameter int unsigned EVT_N     = 128,
    parameter int unsigned LAT_W     = 8,
    parameter int unsigned TB_W      = 64,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned MISS_CODE = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [EVT_N-1:0] evt_i,
    input  logic             miss_vld_i,
    input  logic [LAT_W-1:0] miss_lat_i,
    input  logic [TB_W-1:0]  tb_i,
    input  logic             reg_we_i,
    input  logic [2:0]       reg_addr_i,
    input  logic [31:0]      reg_wdata_i,
    output logic [31:0]      reg_rdata_o,
    output logic [31:0]      usr_ctrl_o,
    output logic             pm_int_o
);

    localparam int unsigned NUM_CNT = 4;
    localparam int unsigned CIDX_W  = $clog2(NUM_CNT);
    localparam int unsigned MSB     = CNT_W - 1;

    typedef struct packed {
        ctrl_t                              ctrl;
        logic [SELN_W-1:0]                  sel3;
        logic [SELN_W-1:0]                  sel4;
        logic [NUM_CNT-1:0][CNT_W-1:0]      cnt;
        logic                               pend;
        logic                               rel;
        logic                               tb_prev;
    } state_t;

    state_t             st_d, st_q;
    logic [NUM_CNT-1:0] hit;
    logic [NUM_CNT-1:0] ovf;
    logic               tb_bit;
    logic               tb_rise;
    logic               trig_hold;
    logic               wr_ctrl;
    logic               wr_cnt_sel;
    logic               int_set;

    // one event selector per counter; PMC1 has the wider select field
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_sel
        if (k == 0) begin : g_wide
            pmu_evt_sel #(
                .EVT_N(EVT_N), .SEL_W(SEL1_W), .LAT_W(LAT_W),
                .THR_W(THR_W), .MISS_CODE(MISS_CODE)
            ) u_sel (
                .evt_i(evt_i), .sel_i(st_q.ctrl.sel1),
                .miss_vld_i(miss_vld_i), .miss_lat_i(miss_lat_i),
                .thresh_i(st_q.ctrl.thresh), .hit_o(hit[k])
            );
        end else begin : g_narrow
            logic [SELN_W-1:0] sel;
            if (k == 1) begin : g_s2
                assign sel = st_q.ctrl.sel2;
            end else if (k == 2) begin : g_s3
                assign sel = st_q.sel3;
            end else begin : g_s4
                assign sel = st_q.sel4;
            end
            pmu_evt_sel #(
                .EVT_N(EVT_N), .SEL_W(SELN_W), .LAT_W(LAT_W),
                .THR_W(THR_W), .MISS_CODE(MISS_CODE)
            ) u_sel (
                .evt_i(evt_i), .sel_i(sel),
                .miss_vld_i(miss_vld_i), .miss_lat_i(miss_lat_i),
                .thresh_i(st_q.ctrl.thresh), .hit_o(hit[k])
            );
        end
    end

    pmu_tb_pick #(.TB_W(TB_W)) u_tb (
        .tb_i(tb_i), .tap_i(st_q.ctrl.tb_tap), .bit_o(tb_bit)
    );

    always_comb begin
        st_d       = st_q;
        wr_ctrl    = reg_we_i && (reg_addr_i == ADR_CTRL);
        wr_cnt_sel = reg_we_i && reg_addr_i[ADDR_W-1];
        trig_hold  = st_q.ctrl.trig && !st_q.rel && !st_q.cnt[0][MSB] && !st_q.pend;
        ovf        = '0;

        for (int k = 0; k < NUM_CNT; k++) begin
            if (wr_cnt_sel && (reg_addr_i[CIDX_W-1:0] == CIDX_W'(k))) begin
                st_d.cnt[k] = CNT_W'(reg_wdata_i);
            end else if (hit[k] && !st_q.ctrl.freeze && !((k != 0) && trig_hold)) begin
                st_d.cnt[k] = st_q.cnt[k] + CNT_W'(1);
            end
            ovf[k] = st_d.cnt[k][MSB] && !st_q.cnt[k][MSB];
        end

        if (wr_ctrl) begin
            st_d.ctrl      = ctrl_t'(reg_wdata_i);
            st_d.ctrl.rsvd = '0;
        end
        if (reg_we_i && (reg_addr_i == ADR_SEL34)) begin
            st_d.sel3 = reg_wdata_i[SELN_W-1:0];
            st_d.sel4 = reg_wdata_i[2*SELN_W-1:SELN_W];
        end

        st_d.tb_prev = tb_bit;
        tb_rise      = tb_bit && !st_q.tb_prev;

        int_set = (st_q.ctrl.tb_ie && tb_rise)
                || (st_q.ctrl.pmc1_ie && ovf[0])
                || (st_q.ctrl.grp_ie && (|ovf[NUM_CNT-1:1]));

        if (reg_we_i && (reg_addr_i == ADR_STAT) && reg_wdata_i[0]) begin
            st_d.pend = 1'b0;
        end
        if (int_set) begin
            st_d.pend = 1'b1;
        end

        st_d.rel = wr_ctrl ? 1'b0 : (st_q.rel || st_q.cnt[0][MSB] || st_q.pend);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i[ADDR_W-1]) begin
            reg_rdata_o = REG_W'(st_q.cnt[reg_addr_i[CIDX_W-1:0]]);
        end else if (reg_addr_i == ADR_CTRL) begin
            reg_rdata_o = st_q.ctrl;
        end else if (reg_addr_i == ADR_SEL34) begin
            reg_rdata_o = REG_W'({st_q.sel4, st_q.sel3});
        end else if (reg_addr_i == ADR_STAT) begin
            reg_rdata_o = REG_W'(st_q.pend);
        end
    end

    assign usr_ctrl_o = st_q.ctrl;
    assign pm_int_o   = st_q.pend;

endmodule

// File: rtl/pmu_core_chk.sv
module pmu_core_chk #(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned NUM_CNT = 4
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         reg_we_i,
    input logic [2:0]                   reg_addr_i,
    input logic [31:0]                  reg_wdata_i,
    input logic [31:0]                  reg_rdata_o,
    input logic [31:0]                  usr_ctrl_o,
    input logic                         pm_int_o,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
    input logic                         hold_i
);

    logic clr_wr;
    assign clr_wr = reg_we_i && (reg_addr_i == 3'd2) && reg_wdata_i[0];

    AST_INT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pm_int_o && !clr_wr) |=> pm_int_o); // R7

    AST_FREEZE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (usr_ctrl_o[0] && !reg_we_i) |=> $stable(cnt_i)); // R9

    AST_TRIG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_i && !(reg_we_i && reg_addr_i == 3'd5)) |=> $stable(cnt_i[1])); // R8

    AST_WR_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_addr_i == 3'd4) |=> (cnt_i[0] == $past(reg_wdata_i))); // R10

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reg_we_i && reg_addr_i == 3'd4)
        |=> ((cnt_i[0] == $past(cnt_i[0])) || (cnt_i[0] == $past(cnt_i[0]) + CNT_W'(1)))); // R3

    AST_USER_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == 3'd0) |-> (reg_rdata_o == usr_ctrl_o)); // R11

    AST_CTRL_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reg_we_i && reg_addr_i == 3'd0) |=> $stable(usr_ctrl_o)); // R11

    AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        usr_ctrl_o[31:26] == 6'd0); // R2

endmodule

bind pmu_core pmu_core_chk #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .usr_ctrl_o(usr_ctrl_o),
    .pm_int_o(pm_int_o), .cnt_i(st_q.cnt), .hold_i(trig_hold)
);

// File: tb/tb_pmu_core.sv
module tb_pmu_core;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] evt = '0;
    logic         miss_vld = 1'b0;
    logic [7:0]   miss_lat = '0;
    logic [63:0]  tb = '0;
    logic         we = 1'b0;
    logic [2:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [31:0]  uctrl;
    logic         irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    pmu_core dut (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .miss_vld_i(miss_vld),
        .miss_lat_i(miss_lat), .tb_i(tb), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .usr_ctrl_o(uctrl), .pm_int_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input int idx, input int n);
        @(negedge clk);
        evt[idx] = 1'b1;
        repeat (n) @(negedge clk);
        evt[idx] = 1'b0;
    endtask

    task automatic clr_all();
        for (int k = 4; k < 8; k++) wr(3'(k), 32'd0);
        wr(3'd2, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reset addr %0d", a), v, 32'd0);
        end
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 user mirror after reset", uctrl, 32'd0);
    endtask

    task automatic t_select();
        logic [31:0] v;
        clr_all();
        wr(3'd1, 32'd9 | (32'd11 << 6));
        wr(3'd0, (32'd5 << 13) | (32'd7 << 20));
        pulse(5, 3); pulse(7, 2); pulse(9, 1); pulse(11, 4);
        rd(3'd4, v); chk("R3 PMC1 code 5", v, 32'd3);
        rd(3'd5, v); chk("R3 PMC2 code 7", v, 32'd2);
        rd(3'd6, v); chk("R3 PMC3 code 9", v, 32'd1);
        rd(3'd7, v); chk("R3 PMC4 code 11", v, 32'd4);
        clr_all();
        wr(3'd1, 32'd0);
        wr(3'd0, 32'd0);
        @(negedge clk); evt = '1;
        repeat (3) @(negedge clk); evt = '0;
        for (int k = 4; k < 8; k++) begin
            rd(3'(k), v); chk($sformatf("R3 code 0 holds counter %0d", k), v, 32'd0);
        end
        wr(3'd0, 32'd100 << 13);
        pulse(100, 2);
        rd(3'd4, v); chk("R3 PMC1 code 100", v, 32'd2);
    endtask

    task automatic t_latency();
        logic [31:0] v;
        clr_all();
        wr(3'd0, (32'd1 << 13) | (32'd10 << 4));
        @(negedge clk); miss_vld = 1'b1; miss_lat = 8'd10;
        @(negedge clk); miss_lat = 8'd11;
        @(negedge clk); miss_vld = 1'b0; miss_lat = 8'd200; evt[1] = 1'b1;
        @(negedge clk); evt[1] = 1'b0;
        rd(3'd4, v); chk("R4 only latency above threshold", v, 32'd1);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        clr_all();
        wr(3'd0, (32'd1 << 10) | (32'd5 << 13) | (32'd7 << 20));
        wr(3'd4, 32'h7FFF_FFFF);
        pulse(5, 1);
        rd(3'd4, v); chk("R5 PMC1 reaches top bit", v, 32'h8000_0000);
        chk("R5 PMC1 overflow raises irq", {31'd0, irq}, 32'd1);
        wr(3'd2, 32'd1);
        pulse(5, 1);
        chk("R5 no second irq without new edge", {31'd0, irq}, 32'd0);
        wr(3'd5, 32'h7FFF_FFFF);
        pulse(7, 1);
        chk("R5 PMC2 overflow with group enable off", {31'd0, irq}, 32'd0);
        wr(3'd0, (32'd1 << 11) | (32'd5 << 13) | (32'd7 << 20));
        wr(3'd5, 32'h7FFF_FFFF);
        pulse(7, 1);
        chk("R5 PMC2 overflow with group enable on", {31'd0, irq}, 32'd1);
        wr(3'd2, 32'd1);
    endtask

    task automatic t_timebase();
        logic [31:0] v;
        int tap [4] = '{0, 8, 12, 16};
        clr_all();
        for (int c = 0; c < 4; c++) begin
            wr(3'd0, (32'(c) << 2) | 32'd2);
            @(negedge clk); tb[tap[c] + 1] = 1'b1;
            @(negedge clk);
            chk($sformatf("R6 code %0d other bit ignored", c), {31'd0, irq}, 32'd0);
            tb[tap[c]] = 1'b1;
            @(negedge clk);
            chk($sformatf("R6 code %0d tap rise", c), {31'd0, irq}, 32'd1);
            rd(3'd0, v);
            chk($sformatf("R11 enable kept after irq code %0d", c), v, (32'(c) << 2) | 32'd2);
            wr(3'd2, 32'd1);
            tb = '0;
            @(negedge clk);
            chk($sformatf("R6 code %0d falling ignored", c), {31'd0, irq}, 32'd0);
        end
        wr(3'd0, 32'd0);
        @(negedge clk); tb[0] = 1'b1;
        @(negedge clk);
        chk("R6 rise with enable off", {31'd0, irq}, 32'd0);
        tb = '0;
        @(negedge clk);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        wr(3'd0, 32'd2);
        @(negedge clk); tb[0] = 1'b1;
        repeat (5) @(negedge clk);
        chk("R7 irq held", {31'd0, irq}, 32'd1);
        rd(3'd2, v); chk("R7 status shows pending", v, 32'd1);
        wr(3'd2, 32'd0);
        chk("R7 write 0 keeps irq", {31'd0, irq}, 32'd1);
        wr(3'd2, 32'd1);
        chk("R7 write 1 clears irq", {31'd0, irq}, 32'd0);
        tb[0] = 1'b0;
        wr(3'd2, 32'd1);
        wr(3'd2, 32'd1);
        @(negedge clk);
        we = 1'b1; addr = 3'd2; wdata = 32'd1; tb[0] = 1'b1;
        @(negedge clk);
        we = 1'b0;
        chk("R7 set beats clear same cycle", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'd0);
        tb = '0;
        wr(3'd2, 32'd1);
    endtask

    task automatic t_trigger();
        logic [31:0] v;
        logic [31:0] cw;
        cw = (32'd1 << 12) | (32'd5 << 13) | (32'd7 << 20);
        clr_all();
        wr(3'd1, 32'd9 | (32'd11 << 6));
        wr(3'd0, cw);
        pulse(7, 3); pulse(9, 3); pulse(11, 3);
        pulse(5, 3);
        rd(3'd5, v); chk("R8 PMC2 held", v, 32'd0);
        rd(3'd7, v); chk("R8 PMC4 held", v, 32'd0);
        rd(3'd4, v); chk("R8 PMC1 counts in trigger mode", v, 32'd3);
        wr(3'd4, 32'h7FFF_FFFF);
        pulse(5, 1);
        pulse(7, 2);
        rd(3'd5, v); chk("R8 PMC2 released by PMC1 top bit", v, 32'd2);
        wr(3'd4, 32'd0);
        pulse(9, 1);
        rd(3'd6, v); chk("R8 release persists", v, 32'd1);
        wr(3'd0, cw);
        pulse(11, 2);
        rd(3'd7, v); chk("R8 control write re-arms hold", v, 32'd0);
        wr(3'd0, cw | 32'd2);
        @(negedge clk); tb[0] = 1'b1;
        @(negedge clk);
        pulse(11, 2);
        rd(3'd7, v); chk("R8 PMC4 released by pending irq", v, 32'd2);
        tb = '0;
        wr(3'd0, 32'd0);
        wr(3'd2, 32'd1);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        clr_all();
        wr(3'd0, 32'd1 | (32'd5 << 13) | (32'd7 << 20));
        pulse(5, 3); pulse(7, 3);
        rd(3'd4, v); chk("R9 PMC1 frozen", v, 32'd0);
        rd(3'd5, v); chk("R9 PMC2 frozen", v, 32'd0);
        wr(3'd6, 32'h0000_1234);
        rd(3'd6, v); chk("R9 write during freeze", v, 32'h0000_1234);
        wr(3'd0, (32'd5 << 13));
        pulse(5, 1);
        rd(3'd4, v); chk("R9 counting after unfreeze", v, 32'd1);
    endtask

    task automatic t_wr_prio();
        logic [31:0] v;
        clr_all();
        wr(3'd0, 32'd5 << 13);
        @(negedge clk);
        evt[5] = 1'b1; we = 1'b1; addr = 3'd4; wdata = 32'h100;
        @(negedge clk);
        we = 1'b0;
        #1; v = rdata;
        chk("R10 write wins over increment", v, 32'h100);
        @(negedge clk);
        evt[5] = 1'b0;
        rd(3'd4, v); chk("R10 increment resumes", v, 32'h101);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R2 reserved control bits read 0", v, 32'h03FF_FFFF);
        chk("R11 user mirror equals control", uctrl, 32'h03FF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v); chk("R2 selector word width", v, 32'h0000_0FFF);
        rd(3'd3, v); chk("R2 address 3 reads 0", v, 32'd0);
        wr(3'd0, 32'd0);
        chk("R11 mirror follows rewrite", uctrl, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_latency();
        t_overflow();
        t_timebase();
        t_sticky();
        t_trigger();
        t_freeze();
        t_wr_prio();
        t_map();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule